// File: doc/BRIEF.md
# In-System Serial Programming Target

This block is the device side of a four-wire in-system programming link. A fast local clock oversamples the host's serial clock and data line. The block frames the incoming stream into four-byte instructions and returns bytes on a serial output so the host can confirm it is in step. It applies the decoded commands to a small on-chip model of a program array and a data array.

Every byte the target receives is shifted back to the host during the following byte. During the programming-enable instruction, this makes the second byte reappear while the third byte is being clocked in. Until that instruction has been accepted, erase, read and write instructions are shifted through but have no effect.

A link-enable input acts as the programming reset. Lowering it drops the framer back to the start of an instruction and withdraws programming permission, which is how a host recovers after losing sync.

Top module: `isp_target`

## Requirements
- R1: Instructions are four bytes, shifted MSB first. Each byte received is shifted back, MSB first, on `miso_o` during the next byte. During the first byte of an instruction, `miso_o` carries the last byte of the previous one.
- R2: `mosi_i` is captured on SCK rising edges. `miso_o` changes only after an SCK falling edge, after the rising edge that ends a byte, or when the link is dropped.
- R3: The instruction 0xAC, 0x53, x, x sets `prog_en_o` after its fourth byte, and 0x53 is on `miso_o` throughout its third byte.
- R4: While `prog_en_o` is low, erase and write instructions leave the arrays unchanged. The fourth byte of a read then returns the echo of the third byte.
- R5: With `link_en_i` low, the bit and byte counters, `miso_o` and `prog_en_o` are cleared. An instruction stream misaligned by stray clocks is recovered by lowering `link_en_i`.
- R6: A read is opcode 0x20 (program array) or 0xA0 (data array), with a don't-care second byte and the address in the third byte. The stored value is returned on `miso_o` during the fourth byte.
- R7: A data-array write is 0xC0, x, addr, data. It replaces the stored byte with no prior erase needed.
- R8: A program-array write is 0x40, x, addr, data. It can only clear bits: the new value is the old value AND data.
- R9: A chip erase is 0xAC, 0x80, x, x. It sets every location of both arrays to 0xFF.
- R10: A read of an address at or beyond the array depth returns 0xFF. A write to such an address changes no location.
- R11: SCK low and high phases must each last more than MIN_PHASE local clock cycles. Operation is correct at MIN_PHASE+1.
- R12: After reset, `miso_o` and `prog_en_o` are 0 and every array location holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_en_i | input | 1 | High while the host holds the target in programming reset |
| sck_i | input | 1 | Serial clock from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| prog_en_o | output | 1 | Programming enable accepted |

## Verification
The bench writes every location of both arrays with two arithmetic patterns. This exposes a design that lets program writes set bits, or that masks data writes instead of replacing them. Out-of-range writes use addresses whose low bits alias address 0, so a design that truncates the address instead of bounding it would corrupt location 0. A one-bit misaligned enable must fail, and it must recover only through the link input; counters that survive the link drop would stay misaligned forever. MISO is sampled at the end of every low phase and again late in the high phase, which catches a shift on the wrong SCK edge or an extra shift at a byte boundary.

// File: rtl/isp_pkg.sv
`timescale 1ns/1ps
package isp_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  localparam logic [7:0] OP_ENTER  = 8'hAC;
  localparam logic [7:0] SUB_SYNC  = 8'h53;
  localparam logic [7:0] SUB_ERASE = 8'h80;
  localparam logic [7:0] OP_RD_P   = 8'h20;
  localparam logic [7:0] OP_RD_D   = 8'hA0;
  localparam logic [7:0] OP_WR_P   = 8'h40;
  localparam logic [7:0] OP_WR_D   = 8'hC0;

  typedef enum logic [1:0] {CMD_NONE, CMD_ERASE, CMD_WRITE} cmd_e;
endpackage

// File: rtl/isp_sck_sync.sv
`timescale 1ns/1ps
module isp_sck_sync #(
  parameter int MIN_PHASE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  localparam int CW = $clog2(MIN_PHASE + 2);

  logic [2:0]    sck_q;
  logic [1:0]    mosi_q;
  logic [CW-1:0] ph_cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  assign rise_o = sck_q[1] & ~sck_q[2];
  assign fall_o = ~sck_q[1] & sck_q[2];
  assign mosi_o = mosi_q[1];

  // phase length monitor, saturates at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_cnt_q <= '0;
      seen_q   <= 1'b0;
    end else if (rise_o || fall_o) begin
      ph_cnt_q <= '0;
      seen_q   <= 1'b1;
    end else if (ph_cnt_q != CW'(MIN_PHASE)) begin
      ph_cnt_q <= ph_cnt_q + CW'(1);
    end
  end

  AST_SCK_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_o || fall_o) && seen_q) |-> (ph_cnt_q == CW'(MIN_PHASE))); // R11
endmodule

// File: rtl/isp_framer.sv
`timescale 1ns/1ps
module isp_framer
  import isp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              bit_i,
  input  logic [BYTE_W-1:0] tx_load_i,
  output logic              byte_done_o,
  output logic [1:0]        byte_idx_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              miso_o
);
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic [BIT_CW-1:0] bit_q;
  logic [1:0]        idx_q;

  assign byte_o      = {sh_q[BYTE_W-2:0], bit_i};
  assign byte_done_o = link_en_i & rise_i & (bit_q == BIT_CW'(BYTE_W - 1));
  assign byte_idx_o  = idx_q;
  assign miso_o      = tx_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      tx_q  <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else if (!link_en_i) begin
      sh_q  <= '0;
      tx_q  <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else begin
      if (rise_i) begin
        sh_q  <= byte_o;
        bit_q <= bit_q + BIT_CW'(1);
      end
      if (byte_done_o) begin
        idx_q <= idx_q + 2'd1;
        tx_q  <= tx_load_i;
      end
      // no shift on the fall that follows a byte load
      if (fall_i && bit_q != '0) tx_q <= tx_q << 1;
    end
  end

  AST_MISO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && !rise_i && !fall_i) |=> $stable(miso_o)); // R2
  AST_LINK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> (bit_q == '0 && idx_q == 2'd0 && !miso_o)); // R5
endmodule

// File: rtl/isp_ctrl.sv
`timescale 1ns/1ps
module isp_ctrl
  import isp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_en_i,
  input  logic              byte_done_i,
  input  logic [1:0]        byte_idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [BYTE_W-1:0] tx_load_o,
  output logic              prog_en_o,
  output cmd_e              cmd_o,
  output logic              sel_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              rd_sel_o,
  output logic [BYTE_W-1:0] rd_addr_o
);
  logic [BYTE_W-1:0] b0_q, b1_q, b2_q;
  logic              en_q;
  logic              last, is_rd, is_wr, is_enter, is_erase;

  assign last     = byte_done_i && (byte_idx_i == 2'd3);
  assign is_rd    = (b0_q == OP_RD_P) || (b0_q == OP_RD_D);
  assign is_wr    = (b0_q == OP_WR_P) || (b0_q == OP_WR_D);
  assign is_enter = (b0_q == OP_ENTER) && (b1_q == SUB_SYNC);
  assign is_erase = (b0_q == OP_ENTER) && (b1_q == SUB_ERASE);

  // array select rides on opcode bit 7
  assign rd_sel_o  = b0_q[7];
  assign rd_addr_o = byte_i;
  assign sel_o     = b0_q[7];
  assign addr_o    = b2_q;
  assign wdata_o   = byte_i;
  assign prog_en_o = en_q;

  always_comb begin
    tx_load_o = byte_i;
    if (byte_idx_i == 2'd2 && is_rd && en_q) tx_load_o = rdata_i;
  end

  always_comb begin
    cmd_o = CMD_NONE;
    if (last && en_q) begin
      if (is_erase)   cmd_o = CMD_ERASE;
      else if (is_wr) cmd_o = CMD_WRITE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b0_q <= '0;
      b1_q <= '0;
      b2_q <= '0;
      en_q <= 1'b0;
    end else if (!link_en_i) begin
      b0_q <= '0;
      b1_q <= '0;
      b2_q <= '0;
      en_q <= 1'b0;
    end else if (byte_done_i) begin
      case (byte_idx_i)
        2'd0: b0_q <= byte_i;
        2'd1: b1_q <= byte_i;
        2'd2: b2_q <= byte_i;
        default: if (is_enter) en_q <= 1'b1;
      endcase
    end
  end

  AST_EN_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_en_o) |-> $past(byte_done_i && byte_idx_i == 2'd3)); // R3
  AST_EN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> !prog_en_o); // R5
endmodule

// File: rtl/isp_mem.sv
`timescale 1ns/1ps
module isp_mem
  import isp_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int DATA_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_sel_i,
  input  logic [BYTE_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int PAW = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;
  localparam int DAW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;
  localparam logic [BYTE_W-1:0] ERASED = '1;

  logic [BYTE_W-1:0] prog_q [PROG_DEPTH];
  logic [BYTE_W-1:0] data_q [DATA_DEPTH];
  logic              prog_hit, data_hit;

  assign prog_hit = (cmd_i == CMD_WRITE) && !sel_i && (addr_i < BYTE_W'(PROG_DEPTH));
  assign data_hit = (cmd_i == CMD_WRITE) &&  sel_i && (addr_i < BYTE_W'(DATA_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PROG_DEPTH; i++) prog_q[i] <= ERASED;
    end else if (cmd_i == CMD_ERASE) begin
      for (int i = 0; i < PROG_DEPTH; i++) prog_q[i] <= ERASED;
    end else if (prog_hit) begin
      // flash cells only program toward zero
      prog_q[addr_i[PAW-1:0]] <= prog_q[addr_i[PAW-1:0]] & wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DATA_DEPTH; i++) data_q[i] <= ERASED;
    end else if (cmd_i == CMD_ERASE) begin
      for (int i = 0; i < DATA_DEPTH; i++) data_q[i] <= ERASED;
    end else if (data_hit) begin
      data_q[addr_i[DAW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = ERASED;
    if (!rd_sel_i && rd_addr_i < BYTE_W'(PROG_DEPTH))
      rdata_o = prog_q[rd_addr_i[PAW-1:0]];
    else if (rd_sel_i && rd_addr_i < BYTE_W'(DATA_DEPTH))
      rdata_o = data_q[rd_addr_i[DAW-1:0]];
  end

  AST_ERASE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ERASE) |=> (prog_q[0] == ERASED && data_q[DATA_DEPTH-1] == ERASED)); // R9
  AST_PROG_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_hit |=> ((prog_q[$past(addr_i[PAW-1:0])] & ~$past(prog_q[addr_i[PAW-1:0]])) == '0)); // R8
endmodule

// File: rtl/isp_target.sv
`timescale 1ns/1ps
module isp_target
  import isp_pkg::*;
#(
  parameter int MIN_PHASE  = 3,
  parameter int PROG_DEPTH = 16,
  parameter int DATA_DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_en_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic prog_en_o
);
  logic              rise, fall, mosi_s, byte_done, sel, rd_sel;
  logic [1:0]        byte_idx;
  logic [BYTE_W-1:0] byte_v, tx_load, addr, wdata, rd_addr, rdata;
  cmd_e              cmd;

  isp_sck_sync #(.MIN_PHASE(MIN_PHASE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .rise_o (rise),
    .fall_o (fall),
    .mosi_o (mosi_s)
  );

  isp_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_en_i   (link_en_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .bit_i       (mosi_s),
    .tx_load_i   (tx_load),
    .byte_done_o (byte_done),
    .byte_idx_o  (byte_idx),
    .byte_o      (byte_v),
    .miso_o      (miso_o)
  );

  isp_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_en_i   (link_en_i),
    .byte_done_i (byte_done),
    .byte_idx_i  (byte_idx),
    .byte_i      (byte_v),
    .rdata_i     (rdata),
    .tx_load_o   (tx_load),
    .prog_en_o   (prog_en_o),
    .cmd_o       (cmd),
    .sel_o       (sel),
    .addr_o      (addr),
    .wdata_o     (wdata),
    .rd_sel_o    (rd_sel),
    .rd_addr_o   (rd_addr)
  );

  isp_mem #(.PROG_DEPTH(PROG_DEPTH), .DATA_DEPTH(DATA_DEPTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .sel_i     (sel),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rd_sel_i  (rd_sel),
    .rd_addr_i (rd_addr),
    .rdata_o   (rdata)
  );
endmodule

// File: tb/sim_isp_target.sv
`timescale 1ns/1ps
module sim_isp_target;
  localparam int PD = 16;
  localparam int DD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_en = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, prog_en;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  int ph = 8;

  always #2.5 clk = ~clk;

  isp_target #(.MIN_PHASE(3), .PROG_DEPTH(PD), .DATA_DEPTH(DD)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .link_en_i (link_en),
    .sck_i     (sck),
    .mosi_i    (mosi),
    .miso_o    (miso),
    .prog_en_o (prog_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sck = 1'b0;
      mosi = d[i];
      repeat (ph) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (ph - 1) @(negedge clk);
      if (i != 0 && miso !== r[i]) viol++;
    end
  endtask

  task automatic instr(input logic [7:0] a, b, c, d, output logic [31:0] r);
    logic [7:0] t;
    xbyte(a, t); r[31:24] = t;
    xbyte(b, t); r[23:16] = t;
    xbyte(c, t); r[15:8]  = t;
    xbyte(d, t); r[7:0]   = t;
  endtask

  task automatic rd(input logic dsel, input logic [7:0] addr, output logic [7:0] v);
    logic [31:0] r;
    instr(dsel ? 8'hA0 : 8'h20, 8'h00, addr, 8'h00, r);
    v = r[7:0];
  endtask

  task automatic wr(input logic dsel, input logic [7:0] addr, input logic [7:0] v);
    logic [31:0] r;
    instr(dsel ? 8'hC0 : 8'h40, 8'h00, addr, v, r);
  endtask

  task automatic link_cycle();
    @(negedge clk);
    link_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 miso after link drop", {31'd0, miso}, 32'd0);
    check("R5 prog_en after link drop", {31'd0, prog_en}, 32'd0);
    link_en = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] pat_d(int a); return 8'((a * 37 + 5) & 255); endfunction
  function automatic logic [7:0] pat_p(int a); return 8'((a * 29 + 156) & 255); endfunction
  function automatic logic [7:0] pat_q(int a); return 8'((a * 13 + 59) & 255); endfunction

  initial begin
    logic [31:0] r;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    check("R12 miso at reset", {31'd0, miso}, 32'd0);
    check("R12 prog_en at reset", {31'd0, prog_en}, 32'd0);
    rst_n = 1'b1;
    link_en = 1'b1;
    repeat (6) @(negedge clk);

    // R4: commands before enable
    wr(1'b1, 8'd1, 8'h12);
    wr(1'b0, 8'd1, 8'h00);
    rd(1'b1, 8'd1, v);
    check("R4 read before enable echoes address", {24'd0, v}, 32'h01);
    instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
    check("R4 prog_en still low", {31'd0, prog_en}, 32'd0);

    // R5: one stray clock misaligns the enable
    @(negedge clk); sck = 1'b0; mosi = 1'b0;
    repeat (ph) @(negedge clk); sck = 1'b1;
    repeat (ph) @(negedge clk);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check("R5 misaligned enable rejected", {31'd0, prog_en}, 32'd0);
    link_cycle();

    // R3 / R1: proper enable
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check("R1 byte1 echoed in byte2", {24'd0, r[23:16]}, 32'hAC);
    check("R3 sync byte on miso in byte3", {24'd0, r[15:8]}, 32'h53);
    check("R1 byte3 echoed in byte4", {24'd0, r[7:0]}, 32'h00);
    check("R3 prog_en set", {31'd0, prog_en}, 32'd1);
    instr(8'h20, 8'h00, 8'h07, 8'h00, r);
    check("R1 last byte of previous instr in byte1", {24'd0, r[31:24]}, 32'h00);
    check("R1 opcode echoed in byte2", {24'd0, r[23:16]}, 32'h20);

    // R4 / R12: earlier writes had no effect, reset content erased
    rd(1'b1, 8'd1, v);
    check("R4 data write before enable ignored", {24'd0, v}, 32'hFF);
    rd(1'b0, 8'd1, v);
    check("R4 prog write before enable ignored", {24'd0, v}, 32'hFF);

    // R6 R7 R8: sweep both arrays
    for (int a = 0; a < DD; a++) wr(1'b1, 8'(a), pat_d(a));
    for (int a = 0; a < PD; a++) wr(1'b0, 8'(a), pat_p(a));
    for (int a = 0; a < DD; a++) begin
      rd(1'b1, 8'(a), v);
      check("R6 R7 data readback", {24'd0, v}, {24'd0, pat_d(a)});
    end
    for (int a = 0; a < PD; a++) begin
      rd(1'b0, 8'(a), v);
      check("R6 R8 prog readback", {24'd0, v}, {24'd0, pat_p(a)});
    end
    for (int a = 0; a < DD; a++) wr(1'b1, 8'(a), ~pat_d(a));
    for (int a = 0; a < PD; a++) wr(1'b0, 8'(a), pat_q(a));
    for (int a = 0; a < DD; a++) begin
      rd(1'b1, 8'(a), v);
      check("R7 data overwrite replaces", {24'd0, v}, {24'd0, ~pat_d(a)});
    end
    for (int a = 0; a < PD; a++) begin
      rd(1'b0, 8'(a), v);
      check("R8 prog write ANDs", {24'd0, v}, {24'd0, pat_p(a) & pat_q(a)});
    end

    // R10: out of range
    rd(1'b0, 8'(PD), v);  check("R10 prog read past depth", {24'd0, v}, 32'hFF);
    rd(1'b0, 8'd255, v);  check("R10 prog read addr 255", {24'd0, v}, 32'hFF);
    rd(1'b1, 8'(DD), v);  check("R10 data read past depth", {24'd0, v}, 32'hFF);
    rd(1'b1, 8'd200, v);  check("R10 data read addr 200", {24'd0, v}, 32'hFF);
    wr(1'b1, 8'(DD), 8'h00);
    wr(1'b0, 8'(PD), 8'h00);
    rd(1'b1, 8'd0, v);
    check("R10 data write past depth no alias", {24'd0, v}, {24'd0, ~pat_d(0)});
    rd(1'b0, 8'd0, v);
    check("R10 prog write past depth no alias", {24'd0, v}, {24'd0, pat_p(0) & pat_q(0)});

    // R11: minimum legal phase
    ph = 4;
    wr(1'b1, 8'd3, 8'h5A);
    ph = 8;
    rd(1'b1, 8'd3, v);
    check("R11 write at minimum phase", {24'd0, v}, 32'h5A);

    // R9: chip erase
    instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
    for (int a = 0; a < DD; a++) begin
      rd(1'b1, 8'(a), v);
      check("R9 data erased", {24'd0, v}, 32'hFF);
    end
    for (int a = 0; a < PD; a++) begin
      rd(1'b0, 8'(a), v);
      check("R9 prog erased", {24'd0, v}, 32'hFF);
    end

    // R5: link drop withdraws permission
    link_cycle();
    wr(1'b1, 8'd2, 8'h77);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check("R5 re-enable echo", {24'd0, r[15:8]}, 32'h53);
    rd(1'b1, 8'd2, v);
    check("R5 write after link drop ignored", {24'd0, v}, 32'hFF);

    check("R2 miso stable through high phases", viol, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule